// File: doc/BRIEF.md
# Dual-Law SPI Serial Clock Generator

This block derives the serial clock of an SPI master from the system clock. A one-bit law select picks between two division rules. Under the exponential law the serial clock period is 2^(N+1) system cycles. Under the linear law the period is 2·(N+1) system cycles. N is an 8-bit divider code, and in both cases the high and low halves are equal. The idle level of the serial clock follows a polarity input.

A transfer engine holds `run` high for as long as it wants clocking. For each clock edge the block raises a one-cycle leading-edge strobe or a one-cycle trailing-edge strobe, which the shifter uses to sample and launch data. The divider code, the law select and the polarity are taken into shadow registers only while `run` is low. A change made during a burst therefore waits for the next idle point. Dropping `run` clears the half-period counter and returns the clock to its idle level.

Top module: `spi_sclk_gen`

## Requirements
- R1: With `lawLin`=0, the half period is H=2^N system cycles for N in 0..15 (period 2^(N+1)). With `run` first sampled high at rising edge 1, the serial clock changes level just after every edge i where i is a multiple of H.
- R2: With `lawLin`=1, the half period is H=N+1 system cycles for N in 0..255 (period 2·(N+1)), with the same edge timing as R1.
- R3: With `lawLin`=0 and N above 15, the divider behaves as N=15 (H=32768).
- R4: While `run` is low, `sclk` sits at the idle level and both strobes stay low. After `run` falls, the next burst restarts its timing from zero.
- R5: `leadStb` is high for exactly one system cycle, in the first cycle where `sclk` has left the idle level. `trailStb` is high for exactly one cycle, in the first cycle where `sclk` is back at idle. The two strobes are never high together.
- R6: `cpol`=1 makes the idle level high and inverts the waveform. `cpol`=0 makes it low.
- R7: Changes to `divCode`, `lawLin` or `cpol` while `run` is high do not alter the current burst. They take effect in the first burst after `run` has been low for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Clock enable from the transfer engine |
| lawLin | input | 1 | 0: exponential law, 1: linear law |
| divCode | input | 8 | Divider code N |
| cpol | input | 1 | Idle level of the serial clock |
| sclk | output | 1 | Serial clock |
| leadStb | output | 1 | One-cycle strobe on each edge leaving idle |
| trailStb | output | 1 | One-cycle strobe on each edge returning to idle |

## Verification
The linear law is swept over codes 0 to 63, plus 127 and 255. The exponential law is swept over codes 0 to 9, with both polarities. Every cycle of two full periods is compared with the closed-form edge index, which separates an off-by-one in the limit from a wrong law or a wrong strobe phase. One exponential run uses a code above 15 and separates saturation from wrap-around. Bursts cut off mid-period show that the counter restarts. A burst where the inputs are changed part-way shows that the shadow registers ignore the new values until idle, and that they take them up afterwards.

// File: rtl/sclk_pkg.sv
package sclk_pkg;
  typedef struct packed {
    logic halfDone;  // current half period ends at this edge
    logic idle;      // run is low: clear datapath state
  } sclk_ctl_t;
endpackage

// File: rtl/sclk_ctrl.sv
module sclk_ctrl
  import sclk_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int EXP_MAX = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic             lawLin,
  input  logic [DIV_W-1:0] divCode,
  output sclk_ctl_t        ctl
);
  localparam int CNT_W = (EXP_MAX + 1 > DIV_W + 1) ? EXP_MAX + 1 : DIV_W + 1;
  localparam int EXP_W = $clog2(EXP_MAX + 1);

  logic [DIV_W-1:0] divQ;
  logic             lawQ;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] halfLim;
  logic [EXP_W-1:0] expSel;

  // shadow configuration: loaded only while idle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divQ <= '0;
      lawQ <= 1'b0;
    end else if (!run) begin
      divQ <= divCode;
      lawQ <= lawLin;
    end
  end

  always_comb begin
    if (divQ > DIV_W'(EXP_MAX)) expSel = EXP_W'(EXP_MAX);
    else                        expSel = divQ[EXP_W-1:0];
    if (lawQ) halfLim = CNT_W'(divQ);
    else      halfLim = (CNT_W'(1) << expSel) - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cnt <= '0;
    else if (!run)            cnt <= '0;
    else if (cnt == halfLim)  cnt <= '0;
    else                      cnt <= cnt + CNT_W'(1);
  end

  assign ctl.halfDone = run && (cnt == halfLim);
  assign ctl.idle     = !run;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= halfLim); // R1
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rstN)
    run |=> ($stable(divQ) && $stable(lawQ))); // R7
  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> cnt == '0); // R4
endmodule

// File: rtl/sclk_dpath.sv
module sclk_dpath
  import sclk_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  sclk_ctl_t ctl,
  input  logic      cpol,
  output logic      sclk,
  output logic      leadStb,
  output logic      trailStb
);
  logic phase;
  logic cpolQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= 1'b0;
      cpolQ    <= 1'b0;
      leadStb  <= 1'b0;
      trailStb <= 1'b0;
    end else if (ctl.idle) begin
      phase    <= 1'b0;
      cpolQ    <= cpol;
      leadStb  <= 1'b0;
      trailStb <= 1'b0;
    end else begin
      phase    <= phase ^ ctl.halfDone;
      leadStb  <= ctl.halfDone && !phase;
      trailStb <= ctl.halfDone && phase;
    end
  end

  assign sclk = cpolQ ^ phase;

  AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(leadStb && trailStb)); // R5
  AST_LEAD_ONE_WIDE: assert property (@(posedge clk) disable iff (!rstN)
    leadStb |=> !leadStb); // R5
  AST_LEAD_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    leadStb |-> sclk != cpolQ); // R5
  AST_TRAIL_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    trailStb |-> sclk == cpolQ); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ctl.idle |=> (!leadStb && !trailStb && sclk == $past(cpol))); // R4
endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen
  import sclk_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int EXP_MAX = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic             lawLin,
  input  logic [DIV_W-1:0] divCode,
  input  logic             cpol,
  output logic             sclk,
  output logic             leadStb,
  output logic             trailStb
);
  sclk_ctl_t ctl;

  sclk_ctrl #(.DIV_W(DIV_W), .EXP_MAX(EXP_MAX)) i_ctrl (
    .clk(clk), .rstN(rstN), .run(run), .lawLin(lawLin),
    .divCode(divCode), .ctl(ctl)
  );

  sclk_dpath i_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cpol(cpol),
    .sclk(sclk), .leadStb(leadStb), .trailStb(trailStb)
  );
endmodule

// File: tb/test_spi_sclk_gen.sv
`timescale 1ns/1ps
module test_spi_sclk_gen;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic run = 1'b0;
  logic lawLin = 1'b0;
  logic [7:0] divCode = '0;
  logic cpol = 1'b0;
  logic sclk, leadStb, trailStb;
  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  spi_sclk_gen i_spi_sclk_gen (
    .clk(clk), .rstN(rstN), .run(run), .lawLin(lawLin),
    .divCode(divCode), .cpol(cpol),
    .sclk(sclk), .leadStb(leadStb), .trailStb(trailStb)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<190000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic int halfOf(input logic lin, input int n);
    if (lin) return n + 1;
    return 1 << ((n > 15) ? 15 : n);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // idle with given config, verify idle state, then burst for nEdges edges.
  // chgAt>0: at that edge change inputs to the alternate config mid-burst (R7).
  task automatic burst(input string req, input logic lin, input int n,
                       input logic pol, input int nEdges,
                       input int chgAt, input logic cLin, input int cN,
                       input logic cPol);
    int h;
    int bad;
    int expV;
    @(negedge clk);
    run = 1'b0; lawLin = lin; divCode = 8'(n); cpol = pol;
    bad = 0;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      if (leadStb || trailStb) bad++;
    end
    check("R4 idle strobes", bad, 0);
    check(pol ? "R6 idle high" : "R6 idle low", int'(sclk), int'(pol));
    @(negedge clk);
    run = 1'b1;
    h = halfOf(lin, n);
    bad = 0;
    for (int i = 1; i <= nEdges; i++) begin
      int m;
      int r;
      @(posedge clk); #1;
      m = i / h; r = i % h;
      expV = int'(pol) ^ (m & 1);
      expV = expV | ((r == 0 && (m & 1) == 1) ? 2 : 0)
                  | ((r == 0 && m > 0 && (m & 1) == 0) ? 4 : 0);
      if ((int'(sclk) | (leadStb ? 2 : 0) | (trailStb ? 4 : 0)) != expV) begin
        if (bad == 0)
          $display("FAIL %s law=%0d N=%0d edge %0d: actual=%0d expected=%0d",
                   req, lin, n, i,
                   int'(sclk) | (leadStb ? 2 : 0) | (trailStb ? 4 : 0), expV);
        bad++;
      end
      if (i == chgAt) begin
        lawLin = cLin; divCode = 8'(cN); cpol = cPol;
      end
    end
    checks++;
    if (bad != 0) errors++;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R4 reset sclk", int'(sclk), 0);
    check("R5 reset strobes", int'(leadStb) + int'(trailStb), 0);
    @(negedge clk); rstN = 1'b1;

    // R2 linear law sweep
    for (int n = 0; n < 64; n++)
      burst("R2", 1'b1, n, n[0], 4 * (n + 1), 0, 1'b0, 0, 1'b0);
    burst("R2", 1'b1, 127, 1'b0, 512, 0, 1'b0, 0, 1'b0);
    burst("R2", 1'b1, 255, 1'b1, 1024, 0, 1'b0, 0, 1'b0);
    // R1 exponential law sweep, both polarities (R6)
    for (int n = 0; n < 10; n++)
      burst("R1", 1'b0, n, n[1], 4 * (1 << n), 0, 1'b0, 0, 1'b0);
    burst("R6", 1'b0, 2, 1'b1, 16, 0, 1'b0, 0, 1'b0);
    // R4 bursts cut mid-period, then fresh timing
    burst("R4 cut", 1'b1, 5, 1'b0, 9, 0, 1'b0, 0, 1'b0);
    burst("R4 restart", 1'b1, 5, 1'b0, 24, 0, 1'b0, 0, 1'b0);
    burst("R4 cut", 1'b0, 3, 1'b1, 13, 0, 1'b0, 0, 1'b0);
    burst("R4 restart", 1'b0, 3, 1'b1, 32, 0, 1'b0, 0, 1'b0);
    // R7 mid-burst change ignored; next burst picks it up
    burst("R7 hold", 1'b1, 3, 1'b0, 40, 5, 1'b0, 0, 1'b1);
    @(negedge clk); run = 1'b0;
    @(posedge clk); #1;
    check("R7 idle after change", int'(sclk), 1);
    burst("R7 applied", 1'b0, 0, 1'b1, 8, 0, 1'b0, 0, 1'b0);
    // R3 saturation above 15
    burst("R3", 1'b0, 200, 1'b0, 32770, 0, 1'b0, 0, 1'b0);
    burst("R5", 1'b1, 0, 1'b0, 8, 0, 1'b0, 0, 1'b0);
    @(negedge clk); run = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule